// File: doc/BRIEF.md
# Three-Tap Streaming FIR Filter

The block is a continuously running finite impulse response filter with three taps. It takes one unsigned sample every clock. Each new sample enters a three-stage delay line, and every stage is multiplied by its own weight. The three products are added, and the result is registered onto the output. No controlling state machine is involved; the datapath updates on every clock edge.

The three weights live in registers that can be loaded one at a time while the filter keeps running. A 2-bit select is decoded to pick the weight to load, and a write strobe qualifies the load. Select value 3 maps to no register. The filter uses whatever weights are present at each edge, so a weight loaded at one edge is first used at the next edge.

Top module: `tap3_fir`

## Requirements
- R1: `y_out` is a register. After the edge that captures sample x(t) into the first delay stage, the next edge loads `y_out` with the low `DW` bits of w0·x(t) + w1·x(t−1) + w2·x(t−2). The weights are those held at that edge.
- R2: The delay line moves one stage per clock and accepts one sample on every edge. With unit weights and the inputs 180, 181, 240 applied on successive edges after an all-zero line, `y_out` reads 0, 180, 361 and then 601.
- R3: When `coef_we` is high at an edge, `coef_in` is loaded into w0, w1 or w2 for `coef_sel` equal to 0, 1 or 2 respectively.
- R4: When `coef_we` is high with `coef_sel` equal to 3, no weight changes.
- R5: When `coef_we` is low, no weight changes, whatever `coef_sel` and `coef_in` hold.
- R6: While `rst` is high at an edge, the delay line, all three weights and `y_out` are cleared to zero. With no later load, `y_out` stays 0 for any input.
- R7: Samples and weights are unsigned. The output is the sum taken modulo 2^`DW`. With every weight and sample at 4095, `y_out` reads 3.
- R8: Loading a weight does not stall the filter. The delay line still shifts on that edge. The output computed at that edge uses the old weight, and the new weight is used from the following edge on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| x_in | input | DW | Unsigned input sample, one per clock |
| coef_we | input | 1 | Weight load strobe |
| coef_sel | input | 2 | Weight select: 0 to 2 pick a weight, 3 selects none |
| coef_in | input | CW | Weight value to load |
| y_out | output | DW | Registered filter output |

## Verification
A wrong weight appears in `y_out` at the first edge where a nonzero sample sits in the matching stage of the delay line. That is no later than three clocks after the sample enters. A wrong delay stage shows up as an output offset by one sample, one edge after the bad value reaches that stage. Errors in the load decode, such as select 3 or an unqualified strobe, appear only through later outputs. For that reason each ignored load is followed by nonzero samples long enough to pass through all three taps.

// File: rtl/tap3_fir.sv
module tap3_fir #(
  parameter int DW = 12,
  parameter int CW = 12
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [DW-1:0] x_in,
  input  logic          coef_we,
  input  logic [1:0]    coef_sel,
  input  logic [CW-1:0] coef_in,
  output logic [DW-1:0] y_out
);
  localparam int NT = 3;
  localparam int PW = DW + CW;

  logic [NT-1:0][DW-1:0] tap;
  logic [NT-1:0][CW-1:0] coef;
  logic [NT-1:0]         load;
  logic [NT-1:0][DW-1:0] prod;
  logic [DW-1:0]         acc;

  always_ff @(posedge clk) begin
    if (rst) tap <= '0;
    else     tap <= {tap[NT-2:0], x_in};
  end

  for (genvar g = 0; g < NT; g++) begin : g_tap
    assign load[g] = coef_we && (coef_sel == 2'(g));

    always_ff @(posedge clk) begin
      if (rst)          coef[g] <= '0;
      else if (load[g]) coef[g] <= coef_in;
    end

    assign prod[g] = DW'(PW'(tap[g]) * PW'(coef[g]));
  end

  assign acc = prod[0] + prod[1] + prod[2];

  always_ff @(posedge clk) begin
    if (rst) y_out <= '0;
    else     y_out <= acc;
  end
endmodule

// File: rtl/tap3_fir_props.sv
module tap3_fir_props #(
  parameter int DW = 12,
  parameter int CW = 12
) (
  input logic                 clk,
  input logic                 rst,
  input logic [DW-1:0]        x_in,
  input logic                 coef_we,
  input logic [1:0]           coef_sel,
  input logic [CW-1:0]        coef_in,
  input logic [DW-1:0]        y_out,
  input logic [2:0][DW-1:0]   tap,
  input logic [2:0][CW-1:0]   coef
);
  a_r2_shift: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (tap[0] == $past(x_in)) && (tap[1] == $past(tap[0])) && (tap[2] == $past(tap[1])));

  a_r3_load_w0: assert property (@(posedge clk) disable iff (rst)
    (coef_we && coef_sel == 2'd0) |=> coef[0] == $past(coef_in));

  a_r3_load_w1: assert property (@(posedge clk) disable iff (rst)
    (coef_we && coef_sel == 2'd1) |=> coef[1] == $past(coef_in));

  a_r3_load_w2: assert property (@(posedge clk) disable iff (rst)
    (coef_we && coef_sel == 2'd2) |=> coef[2] == $past(coef_in));

  a_r4_sel3_none: assert property (@(posedge clk) disable iff (rst)
    (coef_we && coef_sel == 2'd3) |=> $stable(coef));

  a_r5_idle_hold: assert property (@(posedge clk) disable iff (rst)
    !coef_we |=> $stable(coef));

  a_r6_reset_clear: assert property (@(posedge clk)
    rst |=> (y_out == '0) && (tap == '0) && (coef == '0));
endmodule

bind tap3_fir tap3_fir_props #(.DW(DW), .CW(CW)) u_props (
  .clk(clk), .rst(rst), .x_in(x_in), .coef_we(coef_we), .coef_sel(coef_sel),
  .coef_in(coef_in), .y_out(y_out), .tap(tap), .coef(coef)
);

// File: tb/tap3_fir_test.sv
module tap3_fir_test;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst;
  logic [11:0] x_in;
  logic        coef_we;
  logic [1:0]  coef_sel;
  logic [11:0] coef_in;
  logic [11:0] y_out;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  int unsigned mx [3];
  int unsigned mc [3];
  int unsigned my;

  always #(CLK_P/2) clk = ~clk;

  tap3_fir uut (
    .clk(clk), .rst(rst), .x_in(x_in), .coef_we(coef_we),
    .coef_sel(coef_sel), .coef_in(coef_in), .y_out(y_out)
  );

  task automatic check(input string req, input int unsigned act, input int unsigned exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input logic [11:0] x, input bit we, input logic [1:0] sel,
                      input logic [11:0] c, input string req);
    x_in = x; coef_we = we; coef_sel = sel; coef_in = c;
    @(negedge clk);
    my = (mc[0]*mx[0] + mc[1]*mx[1] + mc[2]*mx[2]) & 32'hFFF;
    mx[2] = mx[1]; mx[1] = mx[0]; mx[0] = x;
    if (we && sel != 2'd3) mc[sel] = c;
    check(req, int'(y_out), my);
  endtask

  task automatic load_w(input logic [11:0] a, input logic [11:0] b, input logic [11:0] d);
    step(12'd0, 1'b1, 2'd0, a, "R3");
    step(12'd0, 1'b1, 2'd1, b, "R3");
    step(12'd0, 1'b1, 2'd2, d, "R3");
  endtask

  task automatic do_reset();
    rst = 1'b1; x_in = 12'd77; coef_we = 1'b0; coef_sel = 2'd0; coef_in = 12'd0;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
    for (int i = 0; i < 3; i++) begin mx[i] = 0; mc[i] = 0; end
    my = 0;
    check("R6", int'(y_out), 0);
  endtask

  task automatic t_reset_state();
    do_reset();
    for (int i = 0; i < 4; i++) step(12'(100 + i), 1'b0, 2'd0, 12'd0, "R6");
  endtask

  task automatic t_shift_chain();
    do_reset();
    load_w(12'd1, 12'd1, 12'd1);
    step(12'd180, 1'b0, 2'd0, 12'd0, "R2");
    step(12'd181, 1'b0, 2'd0, 12'd0, "R2");
    check("R2", int'(y_out), 180);
    step(12'd240, 1'b0, 2'd0, 12'd0, "R2");
    check("R2", int'(y_out), 361);
    step(12'd0, 1'b0, 2'd0, 12'd0, "R2");
    check("R2", int'(y_out), 601);
  endtask

  task automatic t_weighted();
    do_reset();
    load_w(12'd3, 12'd5, 12'd7);
    for (int i = 0; i < 6; i++) step(12'(10 * (i + 1)), 1'b0, 2'd0, 12'd0, "R1");
    step(12'd0, 1'b0, 2'd0, 12'd0, "R1");
    check("R1", int'(y_out), 3*60 + 5*50 + 7*40);
    load_w(12'd0, 12'd0, 12'd9);
    for (int i = 0; i < 4; i++) step(12'(i + 2), 1'b0, 2'd0, 12'd0, "R1");
  endtask

  task automatic t_sel3_ignored();
    do_reset();
    load_w(12'd1, 12'd2, 12'd4);
    step(12'd10, 1'b1, 2'd3, 12'd4000, "R4");
    for (int i = 0; i < 4; i++) step(12'd10, 1'b0, 2'd0, 12'd0, "R4");
    check("R4", int'(y_out), 70);
  endtask

  task automatic t_we_low();
    do_reset();
    load_w(12'd1, 12'd1, 12'd1);
    step(12'd7, 1'b0, 2'd0, 12'd500, "R5");
    step(12'd7, 1'b0, 2'd1, 12'd600, "R5");
    step(12'd7, 1'b0, 2'd2, 12'd700, "R5");
    step(12'd7, 1'b0, 2'd0, 12'd0, "R5");
    check("R5", int'(y_out), 21);
  endtask

  task automatic t_wrap();
    do_reset();
    load_w(12'd4095, 12'd4095, 12'd4095);
    for (int i = 0; i < 4; i++) step(12'd4095, 1'b0, 2'd0, 12'd0, "R7");
    check("R7", int'(y_out), 3);
  endtask

  task automatic t_live_write();
    do_reset();
    load_w(12'd2, 12'd0, 12'd0);
    step(12'd5, 1'b0, 2'd0, 12'd0, "R8");
    step(12'd5, 1'b1, 2'd0, 12'd3, "R8");
    check("R8", int'(y_out), 10);
    step(12'd6, 1'b0, 2'd0, 12'd0, "R8");
    check("R8", int'(y_out), 15);
    step(12'd0, 1'b1, 2'd1, 12'd1, "R8");
    check("R8", int'(y_out), 18);
    step(12'd0, 1'b0, 2'd0, 12'd0, "R8");
    check("R8", int'(y_out), 6);
  endtask

  task automatic t_midrun_reset();
    do_reset();
    load_w(12'd9, 12'd9, 12'd9);
    for (int i = 0; i < 3; i++) step(12'd50, 1'b0, 2'd0, 12'd0, "R6");
    do_reset();
    for (int i = 0; i < 4; i++) step(12'd50, 1'b0, 2'd0, 12'd0, "R6");
    check("R6", int'(y_out), 0);
  endtask

  initial begin
    rst = 1'b1; x_in = '0; coef_we = 1'b0; coef_sel = '0; coef_in = '0;
    t_reset_state();
    t_shift_chain();
    t_weighted();
    t_sel3_ignored();
    t_we_low();
    t_wrap();
    t_live_write();
    t_midrun_reset();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(CLK_P * 100000);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule